// File: doc/BRIEF.md
# Asynchronous Serial Port with Guard Time and Receive Timeout

This block is a byte-wide asynchronous serial transmitter and receiver for one peripheral port. Both directions share one oversample tick, which fires once every `cfg_div + 1` clocks. One bit period is 16 ticks. The frame format is set at run time: the number of data bits, the parity mode and the stop length.

The transmitter takes a byte with a valid/ready handshake and sends it. After each frame it holds the line at the mark level for a programmed guard time of 0 to 64 bit periods. Software can force the line to space for a break. A single control inverts the line level in both directions.

The receiver resynchronises the line and oversamples it. It decides each bit by a majority of three samples. It reports each byte with a one-cycle strobe, together with its parity and framing flags. It signals a false start separately. It raises a timeout when the line stays idle for a programmed number of bit periods after a frame.

Top module: `uart_guard_timeout`

## Requirements
- R1: While reset is held and right after it, `txd` is at the mark level (high when `cfg_inv` is 0), `tx_ready` is high and no receive strobe is high.
- R2: A tick occurs every `cfg_div + 1` clocks and every bit lasts 16 ticks. A byte is taken when `tx_valid` and `tx_ready` are high at a clock edge. The frame starts with a space start bit, followed by `cfg_len + 5` data bits sent least significant first; unused upper bits of `tx_data` are ignored. `tx_ready` stays low until the frame and its guard time are over.
- R3: The parity bit follows the data bits. `cfg_par` 1 selects even parity: the bit makes the count of ones, including itself, even. `cfg_par` 2 selects odd parity. `cfg_par` 0 or 3 sends no parity bit.
- R4: The stop bit is at mark level. `cfg_stop` 0 gives 16 ticks, 1 gives 24 ticks and 2 or 3 gives 32 ticks.
- R5: After the stop bit the line stays at mark for min(`cfg_guard`, 64) × 16 ticks, and no new byte is taken during that time.
- R6: While `brk` is high, `txd` is at the space level, `tx_ready` is low and `tx_valid` is ignored.
- R7: With `cfg_inv` at 1, both `txd` and the sampled `rxd` are inverted. Mark is then low on the pin.
- R8: `rxd` passes through two flops and is sampled on every tick. The sample at which a space is first seen is sample 0 of the start bit. Each bit takes the majority of its samples 7, 8 and 9. At sample 9 of the stop bit, `rx_valid` pulses for one cycle with `rx_data`, which holds the data least significant bit first with unused upper bits at zero.
- R9: If the start bit votes mark, `rx_false` pulses for one cycle, no byte is delivered and the receiver returns to idle.
- R10: When parity is enabled and the received parity bit is wrong, `rx_perr` is high together with `rx_valid`.
- R11: When the stop bit votes space, `rx_ferr` is high together with `rx_valid`.
- R12: After an `rx_valid`, if `cfg_tmo` is nonzero and no start is detected for min(`cfg_tmo`, 64) × 16 ticks, `rx_tmo` pulses once, exactly that many ticks after the `rx_valid`. A `cfg_tmo` of 0 disables the timeout.
- R13: `irq` is high in exactly the cycles in which `rx_valid`, `rx_false` or `rx_tmo` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | DIV_W | Tick period minus one, in clocks |
| cfg_len | input | 2 | Data bits minus five |
| cfg_stop | input | 2 | Stop length select |
| cfg_par | input | 2 | Parity select |
| cfg_guard | input | GW | Guard time in bit periods |
| cfg_tmo | input | GW | Receive timeout in bit periods, 0 disables |
| cfg_inv | input | 1 | Invert line level |
| brk | input | 1 | Force break |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Byte received strobe |
| rx_perr | output | 1 | Parity error, with rx_valid |
| rx_ferr | output | 1 | Framing error, with rx_valid |
| rx_false | output | 1 | False start strobe |
| rx_tmo | output | 1 | Idle timeout strobe |
| irq | output | 1 | Any receive event |

## Verification
The bench builds the block with its default parameters, DIV_W of 16 and GUARD_MAX of 64, and runs the divider at 1. A tick then falls on every second clock and a bit lasts 32 clocks. With that setting, a 64-period guard and a clamped guard request of 100 fit inside a short run, as does a full timeout window. Because the tick is slower than the clock, the two-clock glitch used against the majority vote covers exactly one sample.

// File: rtl/uart_guard_timeout.sv
module uart_guard_timeout #(
  parameter int DIV_W = 16,
  parameter int GUARD_MAX = 64,
  localparam int GW = $clog2(GUARD_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_len,
  input  logic [1:0]       cfg_stop,
  input  logic [1:0]       cfg_par,
  input  logic [GW-1:0]    cfg_guard,
  input  logic [GW-1:0]    cfg_tmo,
  input  logic             cfg_inv,
  input  logic             brk,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_perr,
  output logic             rx_ferr,
  output logic             rx_false,
  output logic             rx_tmo,
  output logic             irq
);
  localparam int CW = $clog2(GUARD_MAX * 16 + 1);

  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP, T_GUARD} tx_state_t;
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_state_t;

  logic [DIV_W-1:0] div_cnt;
  logic             tick;
  assign tick = (div_cnt == cfg_div);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                div_cnt <= '0;
    else if (div_cnt >= cfg_div) div_cnt <= '0;
    else                       div_cnt <= div_cnt + 1'b1;

  logic [3:0]    nbits;
  logic [7:0]    mask;
  logic          par_en, par_odd;
  logic [GW-1:0] g_cl, t_cl;
  logic [CW-1:0] stop_ticks, guard_ticks, tmo_ticks, tx_len;

  assign nbits       = 4'd5 + {2'b00, cfg_len};
  assign mask        = 8'hFF >> (4'd8 - nbits);
  assign par_en      = (cfg_par == 2'd1) || (cfg_par == 2'd2);
  assign par_odd     = (cfg_par == 2'd2);
  assign g_cl        = (cfg_guard > GW'(GUARD_MAX)) ? GW'(GUARD_MAX) : cfg_guard;
  assign t_cl        = (cfg_tmo > GW'(GUARD_MAX)) ? GW'(GUARD_MAX) : cfg_tmo;
  assign guard_ticks = CW'(g_cl) << 4;
  assign tmo_ticks   = CW'(t_cl) << 4;

  always_comb
    case (cfg_stop)
      2'd0:    stop_ticks = CW'(16);
      2'd1:    stop_ticks = CW'(24);
      default: stop_ticks = CW'(32);
    endcase

  // transmitter
  tx_state_t     tx_st;
  logic [CW-1:0] tx_tc;
  logic [2:0]    tx_idx;
  logic [7:0]    tx_sh;
  logic          tx_line, tx_pb;

  always_comb
    case (tx_st)
      T_STOP:  tx_len = stop_ticks;
      T_GUARD: tx_len = guard_ticks;
      default: tx_len = CW'(16);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_st   <= T_IDLE;
      tx_tc   <= '0;
      tx_idx  <= '0;
      tx_sh   <= '0;
      tx_line <= 1'b1;
      tx_pb   <= 1'b0;
    end else if (tx_st == T_IDLE) begin
      if (tx_valid && !brk) begin
        tx_st   <= T_START;
        tx_tc   <= '0;
        tx_idx  <= '0;
        tx_sh   <= tx_data;
        tx_line <= 1'b0;
        tx_pb   <= (^(tx_data & mask)) ^ par_odd;
      end
    end else if (tick) begin
      if (tx_tc >= tx_len - 1'b1) begin
        tx_tc <= '0;
        case (tx_st)
          T_START: begin
            tx_st   <= T_DATA;
            tx_line <= tx_sh[0];
          end
          T_DATA:
            if ({1'b0, tx_idx} == nbits - 4'd1) begin
              tx_st   <= par_en ? T_PAR : T_STOP;
              tx_line <= par_en ? tx_pb : 1'b1;
            end else begin
              tx_idx  <= tx_idx + 1'b1;
              tx_sh   <= {1'b0, tx_sh[7:1]};
              tx_line <= tx_sh[1];
            end
          T_PAR: begin
            tx_st   <= T_STOP;
            tx_line <= 1'b1;
          end
          T_STOP:  tx_st <= (guard_ticks == '0) ? T_IDLE : T_GUARD;
          default: tx_st <= T_IDLE;
        endcase
      end else begin
        tx_tc <= tx_tc + 1'b1;
      end
    end

  assign tx_ready = (tx_st == T_IDLE) && !brk;
  assign txd      = (brk ? 1'b0 : tx_line) ^ cfg_inv;

  // receiver
  logic [1:0]    rx_sync;
  logic          rx_in, vote, rx_pe, tmo_arm;
  rx_state_t     rx_st;
  logic [3:0]    rx_k;
  logic [1:0]    rx_v;
  logic [2:0]    rx_idx;
  logic [7:0]    rx_sh;
  logic [CW-1:0] tmo_cnt;

  assign rx_in = rx_sync[1];
  assign vote  = (rx_v[0] & rx_v[1]) | (rx_v[0] & rx_in) | (rx_v[1] & rx_in);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rxd ^ cfg_inv};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_st    <= R_IDLE;
      rx_k     <= '0;
      rx_v     <= '0;
      rx_idx   <= '0;
      rx_sh    <= '0;
      rx_pe    <= 1'b0;
      tmo_arm  <= 1'b0;
      tmo_cnt  <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
      rx_false <= 1'b0;
      rx_tmo   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
      rx_false <= 1'b0;
      rx_tmo   <= 1'b0;
      if (tick) begin
        if (rx_st == R_IDLE) begin
          if (!rx_in) begin
            rx_st   <= R_START;
            rx_k    <= 4'd1;
            tmo_arm <= 1'b0;
          end else if (tmo_arm && tmo_ticks != '0) begin
            if (tmo_cnt >= tmo_ticks - 1'b1) begin
              rx_tmo  <= 1'b1;
              tmo_arm <= 1'b0;
            end else begin
              tmo_cnt <= tmo_cnt + 1'b1;
            end
          end
        end else begin
          rx_k <= rx_k + 1'b1;
          if (rx_k == 4'd7) rx_v[0] <= rx_in;
          if (rx_k == 4'd8) rx_v[1] <= rx_in;
          case (rx_st)
            R_START:
              if (rx_k == 4'd9 && vote) begin
                rx_false <= 1'b1;
                rx_st    <= R_IDLE;
              end else if (rx_k == 4'd15) begin
                rx_st  <= R_DATA;
                rx_idx <= '0;
                rx_sh  <= '0;
                rx_pe  <= 1'b0;
              end
            R_DATA: begin
              if (rx_k == 4'd9) rx_sh[rx_idx] <= vote;
              if (rx_k == 4'd15) begin
                if ({1'b0, rx_idx} == nbits - 4'd1) rx_st <= par_en ? R_PAR : R_STOP;
                else                                rx_idx <= rx_idx + 1'b1;
              end
            end
            R_PAR: begin
              if (rx_k == 4'd9)  rx_pe <= vote ^ (^rx_sh) ^ par_odd;
              if (rx_k == 4'd15) rx_st <= R_STOP;
            end
            default:
              if (rx_k == 4'd9) begin
                rx_valid <= 1'b1;
                rx_data  <= rx_sh;
                rx_perr  <= rx_pe;
                rx_ferr  <= ~vote;
                rx_st    <= R_IDLE;
                tmo_arm  <= 1'b1;
                tmo_cnt  <= '0;
              end
          endcase
        end
      end
    end

  assign irq = rx_valid | rx_false | rx_tmo;
endmodule

// File: rtl/uart_guard_timeout_sva.sv
module uart_guard_timeout_sva (
  input logic clk,
  input logic rst_n,
  input logic brk,
  input logic cfg_inv,
  input logic tx_valid,
  input logic tx_ready,
  input logic txd,
  input logic rx_valid,
  input logic rx_perr,
  input logic rx_ferr,
  input logic rx_false,
  input logic rx_tmo
);
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_break_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && $past(brk) && $stable(cfg_inv)) |-> $stable(txd));

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_events_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, rx_false, rx_tmo}));

  assert_perr_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_perr |-> rx_valid);

  assert_ferr_with_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ferr |-> rx_valid);

  assert_tmo_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tmo |=> !rx_tmo);
endmodule

bind uart_guard_timeout uart_guard_timeout_sva u_sva (
  .clk(clk), .rst_n(rst_n), .brk(brk), .cfg_inv(cfg_inv),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
  .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
  .rx_false(rx_false), .rx_tmo(rx_tmo)
);

// File: tb/uart_guard_timeout_test.sv
module uart_guard_timeout_test;
  localparam int DIV = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] cfg_div = 16'(DIV);
  logic [1:0] cfg_len = 2'd3, cfg_stop = 2'd0, cfg_par = 2'd0;
  logic [6:0] cfg_guard = 7'd0, cfg_tmo = 7'd0;
  logic       cfg_inv = 1'b0, brk = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       loop = 1'b1, drv = 1'b1;
  logic       tx_ready, txd, rxd;
  logic [7:0] rx_data;
  logic       rx_valid, rx_perr, rx_ferr, rx_false, rx_tmo, irq;

  always #10 clk = ~clk;
  assign rxd = loop ? txd : drv;

  uart_guard_timeout uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_stop(cfg_stop), .cfg_par(cfg_par), .cfg_guard(cfg_guard),
    .cfg_tmo(cfg_tmo), .cfg_inv(cfg_inv), .brk(brk), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_false(rx_false), .rx_tmo(rx_tmo), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, n_false = 0;
  bit done = 1'b0;
  int ev_d[$], ev_pe[$], ev_fe[$], ev_cyc[$], tmo_cyc[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural transmitter reference
  int m_div, m_left;
  bit m_busy, m_line, m_tk;
  int q_lvl[$], q_len[$];

  function automatic void load();
    int n, g;
    bit p;
    n = 5 + int'(cfg_len);
    p = (cfg_par == 2'd2);
    for (int i = 0; i < n; i++) begin
      q_lvl.push_back(int'(tx_data[i])); q_len.push_back(16);
      p ^= tx_data[i];
    end
    if (cfg_par == 2'd1 || cfg_par == 2'd2) begin q_lvl.push_back(int'(p)); q_len.push_back(16); end
    q_lvl.push_back(1);
    q_len.push_back(cfg_stop == 2'd0 ? 16 : (cfg_stop == 2'd1 ? 24 : 32));
    g = (cfg_guard > 7'd64) ? 64 : int'(cfg_guard);
    if (g > 0) begin q_lvl.push_back(1); q_len.push_back(16 * g); end
    m_line = 1'b0; m_left = 16; m_busy = 1'b1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_div = 0; m_busy = 1'b0; m_line = 1'b1; q_lvl.delete(); q_len.delete();
    end else begin
      m_tk = (m_div == DIV);
      m_div = m_tk ? 0 : m_div + 1;
      if (m_busy) begin
        if (m_tk) begin
          m_left--;
          if (m_left == 0) begin
            if (q_lvl.size() == 0) begin m_busy = 1'b0; m_line = 1'b1; end
            else begin m_line = bit'(q_lvl.pop_front()); m_left = q_len.pop_front(); end
          end
        end
      end else if (tx_valid && !brk) begin
        load();
      end
    end
  end

  // per-clock comparison, sampled a quarter period after the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk("R2/R3/R4/R6/R7 txd line", 32'(txd), 32'((brk ? 1'b0 : m_line) ^ cfg_inv));
      chk("R5/R6 tx_ready", 32'(tx_ready), 32'(!m_busy && !brk));
      chk("R13 irq", 32'(irq), 32'(rx_valid | rx_false | rx_tmo));
      if (rx_valid) begin
        ev_d.push_back(int'(rx_data)); ev_pe.push_back(int'(rx_perr));
        ev_fe.push_back(int'(rx_ferr)); ev_cyc.push_back(cyc);
      end
      if (rx_false) n_false++;
      if (rx_tmo) tmo_cyc.push_back(cyc);
    end
  end

  task automatic clear();
    ev_d.delete(); ev_pe.delete(); ev_fe.delete(); ev_cyc.delete(); tmo_cyc.delete();
    n_false = 0;
  endtask

  task automatic send(input logic [7:0] d);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_tx();
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic ser(input logic lvl, input int n);
    drv = lvl ^ cfg_inv;
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_byte(input logic [7:0] d, input int nb);
    for (int i = 0; i < nb; i++) ser(d[i], 32);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    int t;
    repeat (3) @(negedge clk);
    chk("R1 reset txd", 32'(txd), 32'd1);
    chk("R1 reset tx_ready", 32'(tx_ready), 32'd1);
    chk("R1 reset rx_valid", 32'(rx_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset txd", 32'(txd), 32'd1);

    // 8N1, no guard, timeout of 2 periods
    clear(); cfg_tmo = 7'd2;
    send(8'hA5); send(8'h3C); wait_tx();
    repeat (200) @(negedge clk);
    chk("R8 frame count", 32'(ev_d.size()), 32'd2);
    if (ev_d.size() == 2) begin
      chk("R8 data 0", 32'(ev_d[0]), 32'hA5);
      chk("R8 data 1", 32'(ev_d[1]), 32'h3C);
      chk("R10 no perr", 32'(ev_pe[0] | ev_pe[1]), 32'd0);
      chk("R11 no ferr", 32'(ev_fe[0] | ev_fe[1]), 32'd0);
      chk("R12 one timeout", 32'(tmo_cyc.size()), 32'd1);
      if (tmo_cyc.size() == 1)
        chk("R12 timeout delay", 32'(tmo_cyc[0] - ev_cyc[1]), 32'(2 * 16 * (DIV + 1)));
    end

    // 5 data bits, even parity, 1.5 stop, guard 3, timeout off
    clear(); cfg_tmo = 7'd0; cfg_len = 2'd0; cfg_par = 2'd1; cfg_stop = 2'd1; cfg_guard = 7'd3;
    send(8'hFF); send(8'h0A); wait_tx();
    repeat (2500) @(negedge clk);
    chk("R3 frame count", 32'(ev_d.size()), 32'd2);
    if (ev_d.size() == 2) begin
      chk("R2 upper bits dropped", 32'(ev_d[0]), 32'h1F);
      chk("R3 data", 32'(ev_d[1]), 32'h0A);
      chk("R3 parity ok", 32'(ev_pe[0] | ev_pe[1]), 32'd0);
    end
    chk("R12 disabled", 32'(tmo_cyc.size()), 32'd0);

    // 7 data bits, odd parity, 2 stop, guard request above the limit
    clear(); cfg_len = 2'd2; cfg_par = 2'd2; cfg_stop = 2'd2; cfg_guard = 7'd100;
    send(8'h55);
    t = 0;
    while (!tx_ready) begin @(negedge clk); t++; end
    chk("R5 guard clamp span", 32'(t == 2400 || t == 2399), 32'd1);
    send(8'h2A); wait_tx();
    repeat (100) @(negedge clk);
    chk("R4 frame count", 32'(ev_d.size()), 32'd2);
    if (ev_d.size() == 2) begin
      chk("R4 data 0", 32'(ev_d[0]), 32'h55);
      chk("R4 data 1", 32'(ev_d[1]), 32'h2A);
      chk("R3 odd parity ok", 32'(ev_pe[0] | ev_pe[1]), 32'd0);
    end

    // inverted line, 6 bits, no parity, guard 1
    clear(); cfg_inv = 1'b1; cfg_len = 2'd1; cfg_par = 2'd0; cfg_stop = 2'd0; cfg_guard = 7'd1;
    @(negedge clk);
    chk("R7 idle low", 32'(txd), 32'd0);
    send(8'h2B); send(8'h15); wait_tx();
    repeat (100) @(negedge clk);
    chk("R7 frame count", 32'(ev_d.size()), 32'd2);
    if (ev_d.size() == 2) begin
      chk("R7 data 0", 32'(ev_d[0]), 32'h2B);
      chk("R7 data 1", 32'(ev_d[1]), 32'h15);
    end
    cfg_inv = 1'b0; cfg_len = 2'd3; cfg_guard = 7'd0;

    // driven line: glitch inside a data bit
    loop = 1'b0; drv = 1'b1;
    repeat (50) @(negedge clk);
    clear();
    ser(1'b0, 32);
    for (int i = 0; i < 8; i++) begin
      if (i == 3) begin ser(1'b1, 15); ser(1'b0, 2); ser(1'b1, 15); end
      else ser(1'b1, 32);
    end
    ser(1'b1, 32); ser(1'b1, 64);
    chk("R8 glitch frame count", 32'(ev_d.size()), 32'd1);
    if (ev_d.size() == 1) chk("R8 majority data", 32'(ev_d[0]), 32'hFF);

    // false start
    clear();
    ser(1'b0, 8); ser(1'b1, 200);
    chk("R9 false start flagged", 32'(n_false), 32'd1);
    chk("R9 no byte", 32'(ev_d.size()), 32'd0);

    // parity error, then a correct parity frame
    clear(); cfg_par = 2'd1;
    ser(1'b0, 32); ser_byte(8'h01, 8); ser(1'b0, 32); ser(1'b1, 32); ser(1'b1, 64);
    ser(1'b0, 32); ser_byte(8'h03, 8); ser(1'b0, 32); ser(1'b1, 32); ser(1'b1, 64);
    chk("R10 frame count", 32'(ev_d.size()), 32'd2);
    if (ev_d.size() == 2) begin
      chk("R10 data", 32'(ev_d[0]), 32'h01);
      chk("R10 perr set", 32'(ev_pe[0]), 32'd1);
      chk("R10 perr clear", 32'(ev_pe[1]), 32'd0);
      chk("R11 ferr clear", 32'(ev_fe[0]), 32'd0);
    end

    // framing error
    clear(); cfg_par = 2'd0;
    ser(1'b0, 32); ser_byte(8'h81, 8); ser(1'b0, 32); ser(1'b1, 200);
    chk("R11 frame seen", 32'(ev_d.size() >= 1), 32'd1);
    if (ev_d.size() >= 1) begin
      chk("R11 data", 32'(ev_d[0]), 32'h81);
      chk("R11 ferr set", 32'(ev_fe[0]), 32'd1);
    end

    // break with an offered byte
    brk = 1'b1; tx_data = 8'h77; tx_valid = 1'b1;
    repeat (40) @(negedge clk);
    chk("R6 line at space", 32'(txd), 32'd0);
    chk("R6 not ready", 32'(tx_ready), 32'd0);
    tx_valid = 1'b0; brk = 1'b0;
    @(negedge clk);
    chk("R6 nothing sent", 32'(txd), 32'd1);
    chk("R6 ready again", 32'(tx_ready), 32'd1);
    repeat (100) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule